// File: doc/BRIEF.md
# Wavetable Tone Generator

This block produces a periodic tone as a stream of 8-bit samples for a DAC. It keeps a phase value in an 8.8 fixed-point accumulator. On every sample-tick strobe it adds a programmable stride to that phase. The upper byte of the phase selects one point of a 256-point pseudo-sine cycle. The block computes that cycle in logic, so no stored table is needed.

The stride carries eight fractional bits. A note whose ideal stride is not a whole number therefore keeps the correct average pitch, because over many ticks the fractional part moves the phase index forward. The output frequency is stride × (tick rate / 256). For example, a 5 kHz tick with a stride of 1.0 gives about 19.5 Hz.

The surrounding system supplies the tick, picks the stride for the wanted note, and may change the stride at any time. When the block is switched off, it parks the output at mid-scale and keeps its phase.

Top module: `wavetable_tone_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the phase to 0, sets `sample` to 0x80 and drives `sample_vld` low. The first sample after reset is therefore the wave value at index 0.
- R2: The wave value at index i (0..255) is defined as follows. Let p = i mod 128 and m = min((p·(128−p)) >> 5, 127). The value is 0x80 + m for i < 128 and 0x80 − m for i ≥ 128.
- R3: A clock edge with `en` and `tick` both high does two things. It loads `sample` with the wave value at the current phase index, which is bits 15:8 of the phase. It also raises `sample_vld` for the following cycle.
- R4: While `en` is high and `tick` is low, `sample` does not change, `sample_vld` is low and the phase does not advance.
- R5: While `en` is low, `sample` reads 0x80, `sample_vld` stays low and ticks are ignored. The phase holds, so after `en` returns high the sequence resumes from the held phase.
- R6: `stride` is an unsigned 8.8 fixed-point value: bits 15:8 are the integer part and bits 7:0 the fraction. On each enabled tick it is added in full to the 16-bit phase, so fractional parts accumulate into the index.
- R7: The phase wraps modulo 2^16, so the index goes from 255 back to 0 with no other effect.
- R8: A new `stride` value is used from the next enabled tick onward. Changing it does not reset or disturb the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Tone enable |
| tick | input | 1 | One-cycle sample-rate strobe |
| stride | input | 16 | Phase step per tick, unsigned 8.8 fixed point |
| sample | output | 8 | Output sample code for the DAC |
| sample_vld | output | 1 | High for one cycle after each produced sample |

## Verification
The assertions cover the behaviour that holds on every cycle. The reset values, the mid-scale parking and missing strobe while disabled, the phase holding while disabled or between ticks, the strobe always tracing back to an enabled tick, and the absence of a zero code are all checked this way. Only the directed scenarios can show that the sample sequence follows the wave definition for a given stride. The same is true for fractional strides moving the index at the right average rate, the index wrapping, resumption from a held phase, and a stride change taking effect at the next tick without a phase jump.

// File: rtl/wt_pkg.sv
// Package: shared default sizes for the wavetable tone generator.
// Assumes the sample code is unsigned with mid-scale at the top bit alone.
package wt_pkg;
    localparam int unsigned WT_ACC_W = 16;  // phase accumulator width
    localparam int unsigned WT_IDX_W = 8;   // wave index width (256 points)
    localparam int unsigned WT_SMP_W = 8;   // output sample width

    // Mid-scale code for an unsigned sample of the default width.
    function automatic logic [WT_SMP_W-1:0] wt_mid_code();
        return WT_SMP_W'(1) << (WT_SMP_W - 1);
    endfunction
endpackage

// File: rtl/wt_phase_acc.sv
// Module: phase accumulator.
// Adds the fixed-point stride to the phase on each enabled tick and wraps
// modulo 2^ACC_W. It assumes the stride has the same width as the phase
// and that tick is a single-cycle strobe. It exposes the integer part as
// the wave index.
module wt_phase_acc #(
    parameter int unsigned ACC_W = 16,
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [ACC_W-1:0] stride,
    output logic [IDX_W-1:0] idx
);
    localparam int unsigned FRAC_W = ACC_W - IDX_W;

    logic [ACC_W-1:0] phase;

    // Advance the phase by one stride per enabled tick; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (en && tick) begin
            phase <= phase + stride;
        end
    end

    // The integer part of the phase addresses the wave.
    assign idx = phase[FRAC_W +: IDX_W];

    AST_PHASE_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase));                                   // R5
    AST_PHASE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(phase));                         // R4
endmodule

// File: rtl/wt_shape_lut.sv
// Module: pseudo-sine wave shaper.
// Maps an index to one point of a parabolic half-wave pair, mirrored around
// mid-scale. It is computed in logic, not stored. It assumes
// 2*(IDX_W-2) >= SMP_W-1, so the scaling shift is non-negative.
module wt_shape_lut #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned SMP_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [SMP_W-1:0] wave
);
    localparam int unsigned PW     = 2 * IDX_W;
    localparam int unsigned HALF   = 1 << (IDX_W - 1);
    localparam int unsigned SHIFT  = 2 * (IDX_W - 2) - (SMP_W - 1);
    localparam int unsigned MAGMAX = (1 << (SMP_W - 1)) - 1;
    localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1);

    logic [PW-1:0]    pos;
    logic [PW-1:0]    rest;
    logic [PW-1:0]    prod;
    logic [PW-1:0]    mag_w;
    logic [SMP_W-1:0] mag;

    // Parabola over each half cycle, clamped to the largest swing; the sign
    // of the half is taken from the top index bit.
    always_comb begin
        pos   = PW'(idx[IDX_W-2:0]);
        rest  = PW'(HALF) - pos;
        prod  = pos * rest;
        mag_w = prod >> SHIFT;
        if (mag_w > PW'(MAGMAX)) begin
            mag = SMP_W'(MAGMAX);
        end else begin
            mag = mag_w[SMP_W-1:0];
        end
        wave = idx[IDX_W-1] ? (MID - mag) : (MID + mag);
    end
endmodule

// File: rtl/wt_out_stage.sv
// Module: output sample register.
// Captures the wave value on each enabled tick and raises a one-cycle
// valid strobe. It parks at mid-scale while disabled. It assumes the wave
// value is valid combinationally in the tick cycle.
module wt_out_stage #(
    parameter int unsigned SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [SMP_W-1:0] wave,
    output logic [SMP_W-1:0] sample,
    output logic             sample_vld
);
    localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1);

    // Register the sample and the strobe; mid-scale on reset or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample     <= MID;
            sample_vld <= 1'b0;
        end else if (!en) begin
            sample     <= MID;
            sample_vld <= 1'b0;
        end else if (tick) begin
            sample     <= wave;
            sample_vld <= 1'b1;
        end else begin
            sample_vld <= 1'b0;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (sample == MID) && !sample_vld);                // R1
    AST_PARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sample == MID) && !sample_vld);                   // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(sample) && !sample_vld);         // R4
    AST_NO_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sample != '0);                                             // R2
endmodule

// File: rtl/wavetable_tone_gen.sv
// Module: wavetable tone generator (top).
// It connects the phase accumulator, the wave shaper and the output
// register. It assumes a single clock, with tick as a one-cycle strobe at
// the sample rate.
module wavetable_tone_gen #(
    parameter int unsigned ACC_W = wt_pkg::WT_ACC_W,
    parameter int unsigned IDX_W = wt_pkg::WT_IDX_W,
    parameter int unsigned SMP_W = wt_pkg::WT_SMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [ACC_W-1:0] stride,
    output logic [SMP_W-1:0] sample,
    output logic             sample_vld
);
    logic [IDX_W-1:0] idx;
    logic [SMP_W-1:0] wave;

    wt_phase_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .stride(stride), .idx(idx)
    );

    wt_shape_lut #(.IDX_W(IDX_W), .SMP_W(SMP_W)) u_lut (
        .idx(idx), .wave(wave)
    );

    wt_out_stage #(.SMP_W(SMP_W)) u_out (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .wave(wave), .sample(sample), .sample_vld(sample_vld)
    );

    AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(en && tick));                         // R3
endmodule

// File: tb/wavetable_tone_gen_bench.sv
module wavetable_tone_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] stride = 16'h0100;
    logic [7:0]  sample;
    logic        sample_vld;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_phase = '0;   // bench model of the phase

    always #4 clk = ~clk;        // 125 MHz

    wavetable_tone_gen u_wavetable_tone_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .stride(stride), .sample(sample), .sample_vld(sample_vld)
    );

    // Wave definition taken from R2.
    function automatic logic [7:0] wave_of(input int i);
        int p, m;
        p = i % 128;
        m = (p * (128 - p)) >> 5;
        if (m > 127) m = 127;
        return (i >= 128) ? 8'(128 - m) : 8'(128 + m);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One enabled tick; checks the captured sample and strobe.
    task automatic tick_chk(input string req);
        logic [7:0] exp;
        exp = wave_of(int'(m_phase[15:8]));
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        m_phase = m_phase + stride;
        chk(req, int'(sample), int'(exp));
        chk(req, int'(sample_vld), 1);
    endtask

    task automatic t_reset;   // R1
        rst_n = 1'b0; en = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sample", int'(sample), 8'h80);
        chk("R1 vld", int'(sample_vld), 0);
        rst_n = 1'b1; en = 1'b1; m_phase = '0;
        stride = 16'h0100;
        tick_chk("R1 first sample");
    endtask

    task automatic t_integer;   // R2 R3 R6
        stride = 16'h0100;
        for (int k = 0; k < 40; k++) tick_chk("R3 stride 1.0");
        stride = 16'h0700;
        for (int k = 0; k < 40; k++) tick_chk("R2 stride 7.0");
    endtask

    task automatic t_idle;   // R4
        logic [7:0] held;
        held = sample;
        @(negedge clk);
        chk("R4 vld low", int'(sample_vld), 0);
        repeat (5) @(negedge clk);
        chk("R4 sample held", int'(sample), int'(held));
        chk("R4 vld low", int'(sample_vld), 0);
        tick_chk("R4 phase kept");
    endtask

    task automatic t_fraction;   // R6
        stride = 16'h0D69;   // about 13.41
        for (int k = 0; k < 60; k++) tick_chk("R6 fractional");
        stride = 16'h0478;   // about 4.47
        for (int k = 0; k < 60; k++) tick_chk("R6 fractional low");
    endtask

    task automatic t_wrap;   // R7
        stride = 16'h4000;
        for (int k = 0; k < 12; k++) tick_chk("R7 wrap 64.0");
        stride = 16'hFF80;
        for (int k = 0; k < 8; k++) tick_chk("R7 wrap near 2^16");
    endtask

    task automatic t_disable;   // R5
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        chk("R5 mid", int'(sample), 8'h80);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        chk("R5 mid", int'(sample), 8'h80);
        chk("R5 vld", int'(sample_vld), 0);
        en = 1'b1;
        tick_chk("R5 resume");
        tick_chk("R5 resume");
    endtask

    task automatic t_change;   // R8
        stride = 16'h0300;
        tick_chk("R8 before");
        @(negedge clk) stride = 16'h1180;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 6; k++) tick_chk("R8 after change");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_integer();
        t_idle();
        t_fraction();
        t_wrap();
        t_disable();
        t_change();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule